// File: doc/BRIEF.md
# Vector Mask Logical Execution Unit

This unit decodes and executes the eight bitwise logical operations that combine two vector mask registers into a third. Each cycle it can accept one instruction word with the current vector length, the mask element spacing, both source mask registers and the old destination value. One cycle later it returns the new destination register value, the destination register number, a write enable and an illegal-instruction flag.

Each mask element is one bit. Element i sits at bit position i×MLEN of a VLEN-bit register, and the bits between elements keep their old values. Elements whose index lies at or above the vector length, up to the last element the register can hold, are cleared. A zero vector length leaves the destination completely untouched and raises no write.

Top module: `vml_unit`

## Requirements
- R1: An instruction is accepted only when bits [6:0] equal 1010111 and bits [14:12] equal 010. Bit 25 has no effect on the result. The destination number is taken from bits [11:7].
- R2: The function code in bits [31:26] selects the operation. 011001 is AND, 011101 NAND, 011000 AND-NOT, 011011 XOR, 011010 OR, 011110 NOR, 011100 OR-NOT and 011111 XNOR.
- R3: For element i, with b the vs2 mask bit and a the vs1 mask bit, the result is OP(b, a). AND-NOT gives b & ~a, OR-NOT gives b | ~a, and NAND, NOR and XNOR are the inverses of AND, OR and XOR.
- R4: Mask element i of every register is the bit at position i×MLEN, and only that bit is read or written for the element.
- R5: Elements with index from vl up to VLEN/MLEN−1 are written as zero. When vl is at or above VLEN/MLEN, every element is computed.
- R6: Destination bits that are not at a multiple of MLEN keep their old value in out_vd.
- R7: When vl is 0, out_we is low and out_vd equals the old destination value.
- R8: MLEN must be a power of two from 1 to 64 and no larger than VLEN. Any other value raises out_illegal, keeps out_we low and returns the old value.
- R9: A function code outside the eight listed, or a wrong opcode or minor code, raises out_illegal, keeps out_we low and returns the old value.
- R10: out_valid pulses exactly one cycle after in_valid, carrying the result of that input. With in_valid low, out_valid is low on the next cycle.
- R11: During and directly after reset, out_valid, out_we and out_illegal are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operation valid |
| instr | input | 32 | Instruction word |
| vl | input | VLW | Current vector length |
| mlen | input | 7 | Mask element spacing in bits |
| vs1_val | input | VLEN | Source mask register vs1 |
| vs2_val | input | VLEN | Source mask register vs2 |
| vd_old | input | VLEN | Current destination register value |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_we | output | 1 | Destination write enable |
| out_illegal | output | 1 | Illegal instruction or spacing |
| out_rd | output | 5 | Destination register number |
| out_vd | output | VLEN | New destination register value |

## Verification
The unit has one register stage, so any wrong internal decision shows at the ports on the cycle after the input. A wrong element map shows up as changed gap bits or misplaced result bits in out_vd. A wrong active-element compare shows up as a stale or non-zero tail bit. A decode slip shows up as a wrong out_illegal or out_we. The bench compares every field on every issued operation, so a fault appears within one operation that uses the affected spacing, length or function code.

// File: rtl/vml_pkg.sv
package vml_pkg;

  typedef enum logic [2:0] {
    MOP_AND, MOP_NAND, MOP_ANDN, MOP_XOR,
    MOP_OR,  MOP_NOR,  MOP_ORN,  MOP_XNOR
  } mop_e;

  typedef struct packed {
    logic hit;
    mop_e op;
  } f6_dec_t;

  localparam logic [6:0] VEC_OPC  = 7'b1010111;
  localparam logic [2:0] MASK_F3  = 3'b010;
  localparam int         MLEN_W   = 7;
  localparam int         MLEN_MAX = 64;

  // funct6 -> operation
  function automatic f6_dec_t decode_f6(input logic [5:0] f6);
    f6_dec_t d;
    d.hit = 1'b1;
    d.op  = MOP_AND;
    case (f6)
      6'b011001: d.op = MOP_AND;
      6'b011101: d.op = MOP_NAND;
      6'b011000: d.op = MOP_ANDN;
      6'b011011: d.op = MOP_XOR;
      6'b011010: d.op = MOP_OR;
      6'b011110: d.op = MOP_NOR;
      6'b011100: d.op = MOP_ORN;
      6'b011111: d.op = MOP_XNOR;
      default:   d.hit = 1'b0;
    endcase
    return d;
  endfunction

  // b comes from vs2, a comes from vs1
  function automatic logic mask_fn(input mop_e op, input logic b, input logic a);
    logic r;
    case (op)
      MOP_AND:  r = b & a;
      MOP_NAND: r = ~(b & a);
      MOP_ANDN: r = b & ~a;
      MOP_XOR:  r = b ^ a;
      MOP_OR:   r = b | a;
      MOP_NOR:  r = ~(b | a);
      MOP_ORN:  r = b | ~a;
      default:  r = ~(b ^ a);
    endcase
    return r;
  endfunction

  function automatic logic mlen_legal(input logic [MLEN_W-1:0] m, input int vlen);
    return (m != '0) && ((m & (m - 1'b1)) == '0) &&
           (int'(m) <= MLEN_MAX) && (int'(m) <= vlen);
  endfunction

  function automatic logic [2:0] mlen_shift(input logic [MLEN_W-1:0] m);
    logic [2:0] s;
    s = '0;
    for (int k = 0; k < MLEN_W; k++)
      if (m[k]) s = 3'(k);
    return s;
  endfunction

endpackage

// File: rtl/vml_decode.sv
module vml_decode
  import vml_pkg::*;
(
  input  logic [31:0] instr,
  output mop_e        op,
  output logic        legal,
  output logic [4:0]  rd
);
  f6_dec_t f6d;
  logic    major_ok;

  always_comb begin
    f6d      = decode_f6(instr[31:26]);
    major_ok = (instr[6:0] == VEC_OPC) && (instr[14:12] == MASK_F3);
    legal    = major_ok && f6d.hit;
    op       = f6d.op;
    rd       = instr[11:7];
  end
endmodule

// File: rtl/vml_mlen_check.sv
module vml_mlen_check
  import vml_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic [MLEN_W-1:0] mlen,
  output logic              ok,
  output logic [2:0]        sh
);
  always_comb begin
    ok = mlen_legal(mlen, VLEN);
    sh = mlen_shift(mlen);
  end
endmodule

// File: rtl/vml_lanes.sv
module vml_lanes
  import vml_pkg::*;
#(
  parameter int VLEN = 128,
  localparam int IDXW = $clog2(VLEN),
  localparam int VLW  = $clog2(VLEN + 1)
) (
  input  mop_e            op,
  input  logic [2:0]      sh,
  input  logic [VLW-1:0]  vl,
  input  logic [VLEN-1:0] vs1,
  input  logic [VLEN-1:0] vs2,
  input  logic [VLEN-1:0] vd_old,
  output logic [VLEN-1:0] res,
  output logic [VLEN-1:0] elem_map,
  output logic [VLEN-1:0] tail_map
);
  logic [IDXW-1:0] low_mask;

  always_comb low_mask = ~({IDXW{1'b1}} << sh);

  for (genvar p = 0; p < VLEN; p++) begin : g_bit
    localparam logic [IDXW-1:0] PV = IDXW'(p);
    logic on_elem;
    logic active;
    always_comb begin
      on_elem = (PV & low_mask) == '0;
      active  = VLW'(PV >> sh) < vl;
    end
    assign elem_map[p] = on_elem;
    assign tail_map[p] = on_elem & ~active;
    assign res[p]      = on_elem ? (active ? mask_fn(op, vs2[p], vs1[p]) : 1'b0)
                                 : vd_old[p];
  end
endmodule

// File: rtl/vml_unit.sv
module vml_unit
  import vml_pkg::*;
#(
  parameter int VLEN = 128,
  localparam int VLW = $clog2(VLEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [VLW-1:0]    vl,
  input  logic [6:0]        mlen,
  input  logic [VLEN-1:0]   vs1_val,
  input  logic [VLEN-1:0]   vs2_val,
  input  logic [VLEN-1:0]   vd_old,
  output logic              out_valid,
  output logic              out_we,
  output logic              out_illegal,
  output logic [4:0]        out_rd,
  output logic [VLEN-1:0]   out_vd
);
  mop_e            dec_op;
  logic            dec_legal;
  logic [4:0]      dec_rd;
  logic            mlen_ok;
  logic [2:0]      mlen_sh;
  logic [VLEN-1:0] lane_res;
  logic [VLEN-1:0] elem_map;
  logic [VLEN-1:0] tail_map;
  logic            op_ok;
  logic            wr_d;
  logic [VLEN-1:0] vd_d;

  vml_decode u_dec (
    .instr (instr), .op (dec_op), .legal (dec_legal), .rd (dec_rd)
  );

  vml_mlen_check #(.VLEN(VLEN)) u_mlen (
    .mlen (mlen), .ok (mlen_ok), .sh (mlen_sh)
  );

  vml_lanes #(.VLEN(VLEN)) u_lanes (
    .op (dec_op), .sh (mlen_sh), .vl (vl), .vs1 (vs1_val), .vs2 (vs2_val),
    .vd_old (vd_old), .res (lane_res), .elem_map (elem_map), .tail_map (tail_map)
  );

  always_comb begin
    op_ok = dec_legal && mlen_ok;
    wr_d  = op_ok && (vl != '0);
    vd_d  = wr_d ? lane_res : vd_old;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_we      <= 1'b0;
      out_illegal <= 1'b0;
      out_rd      <= '0;
      out_vd      <= '0;
    end else begin
      out_valid   <= in_valid;
      out_we      <= in_valid && wr_d;
      out_illegal <= in_valid && !op_ok;
      out_rd      <= dec_rd;
      out_vd      <= vd_d;
    end
  end

  // R1: decode accepts only the vector major opcode and mask minor code
  assert_decode_fields_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_legal |-> (instr[6:0] == VEC_OPC) && (instr[14:12] == MASK_F3));

  // R5: inactive element positions carry zero in the lane result
  assert_tail_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_ok) |-> ((lane_res & tail_map) == '0));

  // R6: gap bits never change between old and new value
  assert_gap_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (((out_vd ^ $past(vd_old)) & ~$past(elem_map)) == '0));

  // R7: zero length gives no write and the old value
  assert_zero_vl_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vl == '0) |=> (!out_we && out_vd == $past(vd_old)));

  // R8: an illegal spacing is flagged
  assert_mlen_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mlen_ok) |=> out_illegal);

  // R9: a flagged operation never writes
  assert_illegal_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> !out_we);

  // R10: output pulse follows an input one cycle earlier
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

endmodule

// File: tb/sim_vml_unit.sv
`timescale 1ns/1ps
module sim_vml_unit;
  localparam int VLEN = 128;
  localparam int VLW  = $clog2(VLEN + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [31:0]       instr = '0;
  logic [VLW-1:0]    vl = '0;
  logic [6:0]        mlen = 7'd1;
  logic [VLEN-1:0]   vs1_val = '0, vs2_val = '0, vd_old = '0;
  logic              out_valid, out_we, out_illegal;
  logic [4:0]        out_rd;
  logic [VLEN-1:0]   out_vd;

  int n_chk = 0;
  int n_bad = 0;

  // truth tables indexed by {b,a}; order matches f6_tab
  logic [5:0] f6_tab [8] = '{6'b011001, 6'b011101, 6'b011000, 6'b011011,
                             6'b011010, 6'b011110, 6'b011100, 6'b011111};
  logic [3:0] tt_tab [8] = '{4'b1000, 4'b0111, 4'b0100, 4'b0110,
                             4'b1110, 4'b0001, 4'b1101, 4'b1001};

  always #2 clk = ~clk;

  vml_unit #(.VLEN(VLEN)) u0 (
    .clk, .rst_n, .in_valid, .instr, .vl, .mlen, .vs1_val, .vs2_val, .vd_old,
    .out_valid, .out_we, .out_illegal, .out_rd, .out_vd
  );

  task automatic chk(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] f6, input logic vm, input logic [4:0] rd,
                                     input logic [2:0] f3, input logic [6:0] opc);
    return {f6, vm, 5'd3, 5'd7, f3, rd, opc};
  endfunction

  task automatic issue(input logic [31:0] ins, input int m, input int len,
                       input logic [VLEN-1:0] a1, input logic [VLEN-1:0] a2,
                       input logic [VLEN-1:0] old);
    int idx;
    bit legal, mok;
    logic [VLEN-1:0] e_vd;
    logic e_we;
    idx = -1;
    for (int k = 0; k < 8; k++) if (ins[31:26] == f6_tab[k]) idx = k;
    mok = 0;
    for (int s = 0; s <= 6; s++) if (m == (1 << s)) mok = 1;
    legal = (ins[6:0] == 7'b1010111) && (ins[14:12] == 3'b010) && (idx >= 0) && mok;
    e_we  = legal && (len != 0);
    e_vd  = old;
    if (e_we) begin
      for (int i = 0; i < VLEN / m; i++) begin
        if (i < len) e_vd[i*m] = tt_tab[idx][{a2[i*m], a1[i*m]}];
        else         e_vd[i*m] = 1'b0;
      end
    end
    in_valid = 1'b1; instr = ins; mlen = 7'(m); vl = VLW'(len);
    vs1_val = a1; vs2_val = a2; vd_old = old;
    @(posedge clk); @(negedge clk);
    chk("R10 out_valid", VLEN'(out_valid), VLEN'(1));
    chk("R1 out_rd", VLEN'(out_rd), VLEN'(ins[11:7]));
    chk("R8/R9 out_illegal", VLEN'(out_illegal), VLEN'(!legal));
    chk("R7 out_we", VLEN'(out_we), VLEN'(e_we));
    chk("R2-R6 out_vd", out_vd, e_vd);
    in_valid = 1'b0;
  endtask

  function automatic logic [VLEN-1:0] rnd();
    logic [VLEN-1:0] r;
    for (int w = 0; w < VLEN; w += 32) r[w +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    #(4 * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [VLEN-1:0] A, B, O;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 out_valid", VLEN'(out_valid), '0);
    chk("R11 out_we", VLEN'(out_we), '0);
    chk("R11 out_illegal", VLEN'(out_illegal), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 after reset valid", VLEN'(out_valid), '0);

    A = rnd(); B = rnd(); O = rnd();
    // R2 R3: every operation, packed spacing, full length
    for (int k = 0; k < 8; k++)
      issue(mk(f6_tab[k], 1'b0, 5'(k + 1), 3'b010, 7'b1010111), 1, VLEN, A, B, O);
    // R3 operand order: vs1 all ones, vs2 all zeros
    issue(mk(6'b011000, 1'b0, 5'd9, 3'b010, 7'b1010111), 1, VLEN, '1, '0, O);
    issue(mk(6'b011100, 1'b0, 5'd9, 3'b010, 7'b1010111), 1, VLEN, '1, '0, O);
    // R1: vm bit set has no effect
    issue(mk(6'b011011, 1'b1, 5'd4, 3'b010, 7'b1010111), 2, 40, A, B, O);
    // R4 R5 R6: spaced elements, partial length
    issue(mk(6'b011010, 1'b0, 5'd5, 3'b010, 7'b1010111), 8, 5, A, B, '1);
    issue(mk(6'b011101, 1'b0, 5'd6, 3'b010, 7'b1010111), 64, 1, '0, '0, '1);
    // R5: length beyond element count
    issue(mk(6'b011111, 1'b0, 5'd7, 3'b010, 7'b1010111), 64, 100, A, B, O);
    // R7: zero length
    issue(mk(6'b011001, 1'b0, 5'd8, 3'b010, 7'b1010111), 4, 0, A, B, O);
    // R8: bad spacings
    issue(mk(6'b011001, 1'b0, 5'd8, 3'b010, 7'b1010111), 3, 10, A, B, O);
    issue(mk(6'b011001, 1'b0, 5'd8, 3'b010, 7'b1010111), 0, 10, A, B, O);
    issue(mk(6'b011001, 1'b0, 5'd8, 3'b010, 7'b1010111), 96, 10, A, B, O);
    // R9: bad function code, opcode, minor code
    issue(mk(6'b000000, 1'b0, 5'd10, 3'b010, 7'b1010111), 1, 10, A, B, O);
    issue(mk(6'b011001, 1'b0, 5'd11, 3'b010, 7'b0110011), 1, 10, A, B, O);
    issue(mk(6'b011001, 1'b0, 5'd12, 3'b001, 7'b1010111), 1, 10, A, B, O);
    // R10: idle cycle
    @(negedge clk);
    chk("R10 idle out_valid", VLEN'(out_valid), '0);
    // mixed back-to-back traffic
    for (int t = 0; t < 300; t++) begin
      int m, len, kk;
      m   = 1 << ($urandom % 7);
      len = $urandom % (VLEN / m + 3);
      kk  = $urandom % 9;
      issue(mk(kk == 8 ? 6'b010101 : f6_tab[kk], 1'($urandom), 5'($urandom), 3'b010,
               7'b1010111), m, len, rnd(), rnd(), rnd());
    end
    @(negedge clk);
    chk("R10 final idle", VLEN'(out_valid), '0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule